// File: doc/BRIEF.md
# Floating-Point Reciprocal Exponent Unit

This unit gives a coarse reciprocal estimate of an IEEE-754 operand by working on the exponent field alone. A finite or infinite input keeps its sign. Its fraction is cleared and its exponent field is bit-inverted. An exponent field of zero, which covers zeros and subnormals, gets a fixed near-maximum exponent instead. NaN inputs follow their own rules: they are quieted or passed through, or replaced by the default NaN when default-NaN mode is on. A signaling NaN raises an invalid-operation flag. The unit does no rounding and no arithmetic on the fraction.

One precision-select input chooses the format. In single-precision mode the operand sits in the low 32 bits of the 64-bit input port. The upper half of the input is then ignored and the upper half of the result is driven to zero. The input is sampled on every clock edge and the result and flag appear on registered outputs one cycle later. Both outputs clear under an asynchronous active-low reset.

Top module: `fp_recip_exp`

## Requirements
- R1: For a non-NaN input, the result sign bit (bit 63 double, bit 31 single) equals the input sign bit and the fraction field (bits 51:0 double, 22:0 single) is zero.
- R2: For a non-NaN input whose exponent field (bits 62:52 double, 30:23 single) is zero, the result exponent field is 0x7FE in double and 0xFE in single precision.
- R3: For a non-NaN input with a nonzero exponent field, the result exponent field is the bitwise complement of the input exponent field, 11 bits wide in double and 8 bits wide in single precision.
- R4: An infinity (exponent all ones, fraction zero) produces a zero of the same sign: every result bit other than the sign bit of the selected format is zero.
- R5: A signaling NaN (exponent all ones, fraction nonzero, fraction MSB clear) sets invalid_o. With default-NaN mode off, it is returned with the fraction MSB (bit 51 double, bit 22 single) set and all other bits unchanged.
- R6: A quiet NaN (exponent all ones, fraction MSB set) with default-NaN mode off is returned unchanged, and invalid_o stays low.
- R7: With dnan_i high, any NaN input returns the default NaN: 0x7FF8000000000000 in double and 0x000000007FC00000 in single precision. invalid_o is still high for a signaling NaN and low for a quiet NaN.
- R8: With dbl_i low (single precision), only op_i[31:0] is used: op_i[63:32] has no effect and res_o[63:32] is zero.
- R9: res_o and invalid_o reflect the inputs present at the previous rising clock edge and do not change between edges. While rst_ni is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 64 | Operand bits; single uses bits 31:0 |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision |
| dnan_i | input | 1 | Default-NaN mode |
| res_o | output | 64 | Registered result |
| invalid_o | output | 1 | Registered invalid-operation flag |

## Verification
The result and the invalid flag are both due exactly one rising edge after the inputs are applied. The bench changes inputs on the falling edge, waits one full cycle and compares on the next falling edge. It also samples once just after a change of input, before any rising edge, to confirm that the outputs still hold the previous result. The checker compares outputs against the inputs of the previous edge using $past. It arms only after the first edge out of reset, so no property looks at a cycle from before reset was released.

// File: rtl/fre_pkg.sv
package fre_pkg;
  localparam int WORD_W = 64;
  localparam int NUM_FMT = 2;

  typedef enum logic {FMT_SP = 1'b0, FMT_DP = 1'b1} fmt_e;

  function automatic int fmt_width(int idx);
    return (idx == int'(FMT_DP)) ? 64 : 32;
  endfunction

  function automatic int fmt_exp_w(int idx);
    return (idx == int'(FMT_DP)) ? 11 : 8;
  endfunction
endpackage

// File: rtl/fre_lane.sv
module fre_lane #(
  parameter int W  = 32,
  parameter int EW = 8
) (
  input  logic [W-1:0] op_i,
  input  logic         dnan_i,
  output logic [W-1:0] res_o,
  output logic         inv_o
);
  localparam int FW = W - 1 - EW;
  localparam logic [EW-1:0] EXP_ONES = '1;
  localparam logic [EW-1:0] EXP_SUB  = EXP_ONES - 1'b1;
  localparam logic [W-1:0]  QBIT     = W'(1) << (FW - 1);
  localparam logic [W-1:0]  DFLT_NAN = {1'b0, EXP_ONES, 1'b1, {(FW-1){1'b0}}};

  logic          sgn;
  logic [EW-1:0] exp_f;
  logic [FW-1:0] frac_f;
  logic          is_nan, is_snan;
  logic [EW-1:0] exp_r;

  assign sgn    = op_i[W-1];
  assign exp_f  = op_i[W-2:FW];
  assign frac_f = op_i[FW-1:0];
  assign is_nan  = (exp_f == EXP_ONES) && (frac_f != '0);
  assign is_snan = is_nan && !frac_f[FW-1];
  assign exp_r   = (exp_f == '0) ? EXP_SUB : ~exp_f;

  always_comb begin
    if (is_nan) res_o = dnan_i ? DFLT_NAN : (op_i | QBIT);
    else        res_o = {sgn, exp_r, {FW{1'b0}}};
    inv_o = is_snan;
  end
endmodule

// File: rtl/fp_recip_exp.sv
module fp_recip_exp
  import fre_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] op_i,
  input  logic              dbl_i,
  input  logic              dnan_i,
  output logic [WORD_W-1:0] res_o,
  output logic              invalid_o
);
  logic [NUM_FMT-1:0][WORD_W-1:0] lane_res;
  logic [NUM_FMT-1:0]             lane_inv;
  fmt_e                           fmt;

  assign fmt = dbl_i ? FMT_DP : FMT_SP;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
    localparam int LW = fmt_width(g);
    localparam int LE = fmt_exp_w(g);
    logic [LW-1:0] r;
    fre_lane #(.W(LW), .EW(LE)) u_lane (
      .op_i  (op_i[LW-1:0]),
      .dnan_i(dnan_i),
      .res_o (r),
      .inv_o (lane_inv[g])
    );
    assign lane_res[g] = WORD_W'(r);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      invalid_o <= 1'b0;
    end else begin
      res_o     <= lane_res[fmt];
      invalid_o <= lane_inv[fmt];
    end
  end
endmodule

// File: rtl/fre_checker.sv
module fre_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [63:0] op_i,
  input logic        dbl_i,
  input logic        dnan_i,
  input logic [63:0] res_o,
  input logic        invalid_o
);
  logic armed;
  logic sgn, ones, fnz, qb, ezero, is_nan, is_snan, is_inf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  always_comb begin
    if (dbl_i) begin
      sgn = op_i[63]; ones = &op_i[62:52]; ezero = op_i[62:52] == '0;
      fnz = |op_i[51:0]; qb = op_i[51];
    end else begin
      sgn = op_i[31]; ones = &op_i[30:23]; ezero = op_i[30:23] == '0;
      fnz = |op_i[22:0]; qb = op_i[22];
    end
    is_nan  = ones && fnz;
    is_snan = is_nan && !qb;
    is_inf  = ones && !fnz;
  end

  AST_SIGN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$past(is_nan) |-> ($past(dbl_i) ? res_o[63] : res_o[31]) == $past(sgn)); // R1
  AST_FRAC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$past(is_nan) |-> ($past(dbl_i) ? res_o[51:0] == '0 : res_o[22:0] == '0)); // R1
  AST_SUB_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$past(is_nan) && $past(ezero)
      |-> ($past(dbl_i) ? res_o[62:52] == 11'h7FE : res_o[30:23] == 8'hFE)); // R2
  AST_INV_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$past(is_nan) && !$past(ezero)
      |-> ($past(dbl_i) ? (res_o[62:52] ^ $past(op_i[62:52])) == 11'h7FF
                        : (res_o[30:23] ^ $past(op_i[30:23])) == 8'hFF)); // R3
  AST_INF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(is_inf) |-> ($past(dbl_i) ? res_o[62:0] == '0 : res_o[30:0] == '0)); // R4
  AST_INVALID_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> invalid_o == $past(is_snan)); // R5
  AST_SNAN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(is_snan) && !$past(dnan_i)
      |-> res_o == ($past(dbl_i) ? ($past(op_i) | 64'h0008_0000_0000_0000)
                                 : {32'h0, $past(op_i[31:0]) | 32'h0040_0000})); // R5
  AST_QNAN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(is_nan) && !$past(is_snan) && !$past(dnan_i)
      |-> res_o == ($past(dbl_i) ? $past(op_i) : {32'h0, $past(op_i[31:0])})); // R6
  AST_DEFAULT_NAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(is_nan) && $past(dnan_i)
      |-> res_o == ($past(dbl_i) ? 64'h7FF8_0000_0000_0000 : 64'h0000_0000_7FC0_0000)); // R7
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$past(dbl_i) |-> res_o[63:32] == '0); // R8
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $stable(op_i) && $stable(dbl_i) && $stable(dnan_i) && $past(armed)
      |=> $stable(res_o) && $stable(invalid_o)); // R9
endmodule

bind fp_recip_exp fre_checker u_fre_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_i     (op_i),
  .dbl_i    (dbl_i),
  .dnan_i   (dnan_i),
  .res_o    (res_o),
  .invalid_o(invalid_o)
);

// File: tb/tb_fp_recip_exp.sv
module tb_fp_recip_exp;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] op_i = '0;
  logic        dbl_i = 1'b0;
  logic        dnan_i = 1'b0;
  logic [63:0] res_o;
  logic        invalid_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  fp_recip_exp dut (.*);

  // Expected value from the requirements: {invalid, result}
  function automatic logic [64:0] model(logic [63:0] op, logic dbl, logic dnan);
    logic [63:0] r;
    logic inv;
    inv = 1'b0;
    if (dbl) begin
      if (op[62:52] == 11'h7FF && op[51:0] != 0) begin
        inv = ~op[51];
        r = dnan ? 64'h7FF8_0000_0000_0000 : {op[63:52], 1'b1, op[50:0]};
      end else if (op[62:52] == 0) r = {op[63], 11'h7FE, 52'h0};
      else r = {op[63], 11'h7FF - op[62:52], 52'h0};
    end else begin
      if (op[30:23] == 8'hFF && op[22:0] != 0) begin
        inv = ~op[22];
        r = dnan ? 64'h7FC0_0000 : {32'h0, op[31:23], 1'b1, op[21:0]};
      end else if (op[30:23] == 0) r = {32'h0, op[31], 8'hFE, 23'h0};
      else r = {32'h0, op[31], 8'hFF - op[30:23], 23'h0};
    end
    return {inv, r};
  endfunction

  task automatic check(string tag, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got inv=%b res=%h, expected inv=%b res=%h",
               tag, act[64], act[63:0], exp[64], exp[63:0]);
    end
  endtask

  task automatic run(string tag, logic [63:0] op, logic dbl, logic dnan);
    op_i = op; dbl_i = dbl; dnan_i = dnan;
    @(negedge clk_i);
    check(tag, {invalid_o, res_o}, model(op, dbl, dnan));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    op_i = 64'h7FF0_0000_0000_0001; dbl_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R9 reset", {invalid_o, res_o}, 65'h0);
    rst_ni = 1'b1;

    run("R2 dp +0",        64'h0000_0000_0000_0000, 1, 0);
    run("R2 dp subnormal", 64'h8000_0000_0000_1234, 1, 0);
    run("R2 sp -0",        64'h0000_0000_8000_0000, 0, 0);
    run("R2 sp subnormal", 64'h0000_0000_0000_0001, 0, 0);
    run("R3 dp 1.0",       64'h3FF0_0000_0000_0000, 1, 0);
    run("R3 sp -max",      64'h0000_0000_FF7F_FFFF, 0, 0);
    run("R1 dp sign",      64'hC123_4567_89AB_CDEF, 1, 0);
    run("R4 dp -inf",      64'hFFF0_0000_0000_0000, 1, 0);
    run("R4 sp +inf",      64'h0000_0000_7F80_0000, 0, 0);
    run("R5 dp snan",      64'hFFF0_0000_0000_0001, 1, 0);
    run("R5 sp snan",      64'h0000_0000_7FA0_0000, 0, 0);
    run("R6 dp qnan",      64'h7FFC_0000_0000_00AB, 1, 0);
    run("R6 sp qnan",      64'h0000_0000_FFC0_0001, 0, 0);
    run("R7 dp snan dflt", 64'hFFF4_0000_0000_0000, 1, 1);
    run("R7 sp qnan dflt", 64'h0000_0000_FFFF_FFFF, 0, 1);
    run("R7 sp snan dflt", 64'h0000_0000_7F80_0001, 0, 1);
    run("R7 dp nonnan",    64'h4000_0000_0000_0000, 1, 1);
    run("R8 sp upper junk", 64'hFFFF_FFFF_3F80_0000, 0, 0);
    run("R8 sp upper nan",  64'h7FF0_0000_0000_0000, 0, 0);

    // R9: output holds until the next rising edge
    op_i = 64'h0000_0000_4000_0000; dbl_i = 1'b0; dnan_i = 1'b0;
    #1;
    check("R9 hold", {invalid_o, res_o}, model(64'h7FF0_0000_0000_0000, 0, 0));
    @(negedge clk_i);
    check("R9 latency", {invalid_o, res_o}, model(64'h0000_0000_4000_0000, 0, 0));

    for (int i = 0; i < 600; i++) begin
      logic [63:0] v;
      logic dbl;
      int cls;
      v = {$urandom, $urandom};
      dbl = $urandom % 2;
      cls = $urandom % 6;
      case (cls)
        1: if (dbl) v[62:52] = '0; else v[30:23] = '0;
        2: if (dbl) begin v[62:52] = '1; v[51:0] = '0; end
           else begin v[30:23] = '1; v[22:0] = '0; end
        3: if (dbl) begin v[62:52] = '1; v[51] = 1'b0; v[0] = 1'b1; end
           else begin v[30:23] = '1; v[22] = 1'b0; v[0] = 1'b1; end
        4: if (dbl) begin v[62:52] = '1; v[51] = 1'b1; end
           else begin v[30:23] = '1; v[22] = 1'b1; end
        default: ;
      endcase
      case (cls)
        1: run("R2 random", v, dbl, $urandom % 2);
        2: run("R4 random", v, dbl, $urandom % 2);
        3: run("R5 random", v, dbl, $urandom % 2);
        4: run("R6 random", v, dbl, $urandom % 2);
        default: run("R3 random", v, dbl, $urandom % 2);
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule